// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block owns the status and configuration registers of a 128 KB serial flash and rules on every command that could change the array or those registers. The command decoder hands it one strobe per decoded command, together with the target address and the data byte of a register write. The block answers each write-class command with a one-cycle grant or deny pulse. With a grant it also gives the inclusive address range that the array sequencer should touch. It raises a busy flag from the moment a program, erase or status write is accepted until the array timer signals completion.

Protection comes from two sources. The first is a 2-bit region code held in non-volatile bits, which covers nothing, the top quarter, the top half or the whole array. The second is an optional split of the bottom 4 KB sector into four 1 KB subsectors, each with its own protect bit. The split is held in volatile configuration bits and can only be switched on while the region code covers the whole array. Once it is on, the subsector bits alone decide protection inside sector 0.

There are two resets. The power-on reset clears only the volatile state. The non-volatile reset models a blank device and clears everything.

Top module: `sflash_wprot_ctrl`

## Requirements
- R1: The power-on reset clears the write latch, busy and the whole configuration byte, but keeps the region code and the lock bit. The non-volatile reset clears all of them.
- R2: The status byte reads busy at bit 0, the write latch at bit 1, the region code at bits 3:2 and the lock bit at bit 7, with the other bits 0. A write-enable command sets the latch and a write-disable command clears it.
- R3: Any status write, configuration write, page program, sector erase, block erase or chip erase issued while the write latch is 0 is denied.
- R4: The grant or deny pulse appears in the cycle after the command cycle, and the two are never high together. A denied command clears the write latch and leaves busy at 0.
- R5: A granted program, erase or status write sets busy. The next `array_done` pulse clears busy and the write latch. A granted configuration write does not set busy, and it clears the write latch at once.
- R6: While busy is 1, every write-class command is denied.
- R7: A status write is denied while the lock bit is 1 and `wp_n` is low. When granted, it loads the region code from `wdata[3:2]` and the lock bit from `wdata[7]`.
- R8: The region code protects nothing at 0, addresses 0x18000 and up at 1, addresses 0x10000 and up at 2, and the whole array at 3. A page program, sector erase or block erase whose address is protected is denied.
- R9: Configuration bit 0 is the split enable and bits 4:1 are the subsector protect bits, where bit 1+i covers subsector i. A configuration write sets the split enable only when the region code is 3. A granted status write with a region code other than 3 clears the split enable.
- R10: With the split enable at 1, a program or sector erase in 0x0000–0x0FFF is protected only by the subsector bit for address bits 11:10, whatever the region code. With the split enable at 0, the subsector bits have no effect.
- R11: A chip erase is granted only when the region code is 0.
- R12: The granted range is the address to the end of its 256-byte page for a program, the 4 KB sector for a sector erase (or the 1 KB subsector when the split is on and the address is in sector 0), the 32 KB block for a block erase, and 0–0x1FFFF for a chip erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears volatile state |
| nv_rst_n | input | 1 | Non-volatile reset, active low, clears everything |
| cmd_wren | input | 1 | Write-enable command strobe |
| cmd_wrdi | input | 1 | Write-disable command strobe |
| cmd_wrsr | input | 1 | Status write command strobe |
| cmd_wrcr | input | 1 | Configuration write command strobe |
| cmd_pp | input | 1 | Page program command strobe |
| cmd_se | input | 1 | Sector erase command strobe |
| cmd_be | input | 1 | Block erase command strobe |
| cmd_ce | input | 1 | Chip erase command strobe |
| addr | input | 17 | Target byte address |
| wdata | input | 8 | Data byte for register writes |
| wp_n | input | 1 | Write-protect pin, active low |
| array_done | input | 1 | Completion pulse from the array timer |
| grant | output | 1 | Command accepted pulse |
| deny | output | 1 | Command refused pulse |
| grant_lo | output | 17 | First address of the granted operation |
| grant_hi | output | 17 | Last address of the granted operation |
| status_o | output | 8 | Status byte |
| config_o | output | 8 | Configuration byte |
| busy | output | 1 | Operation in progress |

## Verification
The main sweep covers four region codes with the split off, then the region code 3 with the split on under all sixteen subsector masks. For each of these it issues a program, a sector erase and a block erase at 128 addresses, one inside every 1 KB step. This separates the quarter boundaries from one another and shows the subsector override inside sector 0 against the region code outside it. It also shows the different range each erase reports. Directed sequences cover the remaining gating rules: no write latch, busy, lock bit with the pin low, chip erase under a non-zero code, a split request refused or cleared, and subsector bits with no effect. A final sequence applies the power-on reset after non-volatile bits are set and checks that they survive.

// File: rtl/sfwp_pkg.sv
`timescale 1ns/1ps
package sfwp_pkg;
  typedef enum logic [3:0] {
    OP_NONE, OP_WREN, OP_WRDI, OP_WRSR, OP_WRCR, OP_PP, OP_SE, OP_BE, OP_CE
  } op_e;

  localparam int RC_W      = 2;
  localparam int ST_BUSY   = 0;
  localparam int ST_WEL    = 1;
  localparam int ST_RC_LSB = 2;
  localparam int ST_LOCK   = 7;
  localparam int CF_SPLIT  = 0;
  localparam int CF_SUB    = 1;

  function automatic logic is_write_class(op_e op);
    return (op == OP_WRSR) || (op == OP_WRCR) || (op == OP_PP) ||
           (op == OP_SE) || (op == OP_BE) || (op == OP_CE);
  endfunction
endpackage

// File: rtl/sfwp_rst_sync.sv
`timescale 1ns/1ps
module sfwp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/sfwp_cmd_sel.sv
`timescale 1ns/1ps
module sfwp_cmd_sel
  import sfwp_pkg::*;
(
  input  logic cmd_wren,
  input  logic cmd_wrdi,
  input  logic cmd_wrsr,
  input  logic cmd_wrcr,
  input  logic cmd_pp,
  input  logic cmd_se,
  input  logic cmd_be,
  input  logic cmd_ce,
  output op_e  op
);
  always_comb begin
    if      (cmd_wrdi) op = OP_WRDI;
    else if (cmd_wren) op = OP_WREN;
    else if (cmd_wrsr) op = OP_WRSR;
    else if (cmd_wrcr) op = OP_WRCR;
    else if (cmd_pp)   op = OP_PP;
    else if (cmd_se)   op = OP_SE;
    else if (cmd_be)   op = OP_BE;
    else if (cmd_ce)   op = OP_CE;
    else               op = OP_NONE;
  end
endmodule

// File: rtl/sfwp_region_check.sv
`timescale 1ns/1ps
module sfwp_region_check
  import sfwp_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int SECTOR_W = 12,
  parameter int BLOCK_W  = 15,
  parameter int PAGE_W   = 8,
  parameter int SUB_W    = 10,
  localparam int SUBIDX_W = SECTOR_W - SUB_W,
  localparam int SUB_N    = 1 << SUBIDX_W
) (
  input  op_e               op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [RC_W-1:0]   rcode,
  input  logic              split_en,
  input  logic [SUB_N-1:0]  sub_prot,
  output logic              locked,
  output logic [ADDR_W-1:0] lo,
  output logic [ADDR_W-1:0] hi
);
  logic [1:0]          quarter;
  logic                region_hit;
  logic                in_sector0;
  logic                split_active;
  logic [SUB_N-1:0]    sub_sel;
  logic                sub_hit;

  assign quarter    = addr[ADDR_W-1 -: 2];
  assign in_sector0 = (addr[ADDR_W-1:SECTOR_W] == '0);

  always_comb begin
    unique case (rcode)
      2'd0:    region_hit = 1'b0;
      2'd1:    region_hit = (quarter == 2'd3);
      2'd2:    region_hit = quarter[1];
      default: region_hit = 1'b1;
    endcase
  end

  for (genvar i = 0; i < SUB_N; i++) begin : g_sub
    assign sub_sel[i] = sub_prot[i] && (addr[SECTOR_W-1:SUB_W] == SUBIDX_W'(i));
  end
  assign sub_hit      = |sub_sel;
  assign split_active = split_en && in_sector0;

  always_comb begin
    locked = 1'b0;
    lo     = '0;
    hi     = '0;
    unique case (op)
      OP_PP: begin
        locked = split_active ? sub_hit : region_hit;
        lo     = addr;
        hi     = {addr[ADDR_W-1:PAGE_W], {PAGE_W{1'b1}}};
      end
      OP_SE: begin
        locked = split_active ? sub_hit : region_hit;
        if (split_active) begin
          lo = {addr[ADDR_W-1:SUB_W], {SUB_W{1'b0}}};
          hi = {addr[ADDR_W-1:SUB_W], {SUB_W{1'b1}}};
        end else begin
          lo = {addr[ADDR_W-1:SECTOR_W], {SECTOR_W{1'b0}}};
          hi = {addr[ADDR_W-1:SECTOR_W], {SECTOR_W{1'b1}}};
        end
      end
      OP_BE: begin
        locked = region_hit;
        lo     = {addr[ADDR_W-1:BLOCK_W], {BLOCK_W{1'b0}}};
        hi     = {addr[ADDR_W-1:BLOCK_W], {BLOCK_W{1'b1}}};
      end
      OP_CE: begin
        locked = (rcode != '0);
        lo     = '0;
        hi     = '1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sfwp_nv_regs.sv
`timescale 1ns/1ps
module sfwp_nv_regs
  import sfwp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [RC_W-1:0] rcode_in,
  input  logic            lock_in,
  output logic [RC_W-1:0] rcode,
  output logic            lock
);
  logic [RC_W-1:0] rcode_d;
  logic            lock_d;

  always_comb begin
    rcode_d = rcode;
    lock_d  = lock;
    if (load) begin
      rcode_d = rcode_in;
      lock_d  = lock_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcode <= '0;
      lock  <= 1'b0;
    end else begin
      rcode <= rcode_d;
      lock  <= lock_d;
    end
  end
endmodule

// File: rtl/sflash_wprot_ctrl.sv
`timescale 1ns/1ps
module sflash_wprot_ctrl
  import sfwp_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int SECTOR_W = 12,
  parameter int BLOCK_W  = 15,
  parameter int PAGE_W   = 8,
  parameter int SUB_W    = 10,
  localparam int SUB_N   = 1 << (SECTOR_W - SUB_W)
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              nv_rst_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic              cmd_wrcr,
  input  logic              cmd_pp,
  input  logic              cmd_se,
  input  logic              cmd_be,
  input  logic              cmd_ce,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wp_n,
  input  logic              array_done,
  output logic              grant,
  output logic              deny,
  output logic [ADDR_W-1:0] grant_lo,
  output logic [ADDR_W-1:0] grant_hi,
  output logic [7:0]        status_o,
  output logic [7:0]        config_o,
  output logic              busy
);
  localparam logic [RC_W-1:0] RC_ALL = '1;

  logic vol_rst_n, nv_srst_n;
  sfwp_rst_sync #(.STAGES(2)) u_vol_sync (.clk(clk), .arst_n(por_n & nv_rst_n), .srst_n(vol_rst_n));
  sfwp_rst_sync #(.STAGES(2)) u_nv_sync  (.clk(clk), .arst_n(nv_rst_n),         .srst_n(nv_srst_n));

  op_e op;
  sfwp_cmd_sel u_sel (
    .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr), .cmd_wrcr(cmd_wrcr),
    .cmd_pp(cmd_pp), .cmd_se(cmd_se), .cmd_be(cmd_be), .cmd_ce(cmd_ce), .op(op)
  );

  logic [RC_W-1:0] rcode;
  logic            lock;
  logic            nv_load;
  logic            unused_wdata;
  assign unused_wdata = ^wdata[6:5];

  sfwp_nv_regs u_nv (
    .clk(clk), .rst_n(nv_srst_n), .load(nv_load),
    .rcode_in(wdata[ST_RC_LSB +: RC_W]), .lock_in(wdata[ST_LOCK]),
    .rcode(rcode), .lock(lock)
  );

  logic              wel_q, wel_d;
  logic              busy_q, busy_d;
  logic              split_q, split_d;
  logic [SUB_N-1:0]  sub_q, sub_d;
  logic              grant_d, deny_d;
  logic [ADDR_W-1:0] lo_q, lo_d, hi_q, hi_d;

  logic              locked;
  logic [ADDR_W-1:0] rlo, rhi;

  sfwp_region_check #(
    .ADDR_W(ADDR_W), .SECTOR_W(SECTOR_W), .BLOCK_W(BLOCK_W),
    .PAGE_W(PAGE_W), .SUB_W(SUB_W)
  ) u_region (
    .op(op), .addr(addr), .rcode(rcode), .split_en(split_q), .sub_prot(sub_q),
    .locked(locked), .lo(rlo), .hi(rhi)
  );

  logic blocked;
  always_comb begin
    unique case (op)
      OP_WRSR: blocked = lock && !wp_n;
      OP_WRCR: blocked = 1'b0;
      default: blocked = locked;
    endcase
  end

  always_comb begin
    wel_d   = wel_q;
    busy_d  = busy_q;
    split_d = split_q;
    sub_d   = sub_q;
    lo_d    = lo_q;
    hi_d    = hi_q;
    grant_d = 1'b0;
    deny_d  = 1'b0;
    nv_load = 1'b0;

    if (busy_q && array_done) begin
      busy_d = 1'b0;
      wel_d  = 1'b0;
    end

    if (op == OP_WREN) begin
      wel_d = 1'b1;
    end else if (op == OP_WRDI) begin
      wel_d = 1'b0;
    end else if (is_write_class(op)) begin
      if (wel_q && !busy_q && !blocked) begin
        grant_d = 1'b1;
        lo_d    = rlo;
        hi_d    = rhi;
        unique case (op)
          OP_WRSR: begin
            nv_load = 1'b1;
            busy_d  = 1'b1;
            if (wdata[ST_RC_LSB +: RC_W] != RC_ALL) split_d = 1'b0;
          end
          OP_WRCR: begin
            split_d = wdata[CF_SPLIT] && (rcode == RC_ALL);
            sub_d   = wdata[CF_SUB +: SUB_N];
            wel_d   = 1'b0;
          end
          default: busy_d = 1'b1;
        endcase
      end else begin
        deny_d = 1'b1;
        wel_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge vol_rst_n) begin
    if (!vol_rst_n) begin
      wel_q   <= 1'b0;
      busy_q  <= 1'b0;
      split_q <= 1'b0;
      sub_q   <= '0;
      grant   <= 1'b0;
      deny    <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      wel_q   <= wel_d;
      busy_q  <= busy_d;
      split_q <= split_d;
      sub_q   <= sub_d;
      grant   <= grant_d;
      deny    <= deny_d;
      lo_q    <= lo_d;
      hi_q    <= hi_d;
    end
  end

  always_comb begin
    status_o                      = '0;
    status_o[ST_BUSY]             = busy_q;
    status_o[ST_WEL]              = wel_q;
    status_o[ST_RC_LSB +: RC_W]   = rcode;
    status_o[ST_LOCK]             = lock;
    config_o                      = '0;
    config_o[CF_SPLIT]            = split_q;
    config_o[CF_SUB +: SUB_N]     = sub_q;
  end

  assign busy     = busy_q;
  assign grant_lo = lo_q;
  assign grant_hi = hi_q;
endmodule

// File: rtl/sfwp_checker.sv
`timescale 1ns/1ps
module sfwp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       array_done,
  input logic       grant,
  input logic       deny,
  input logic [7:0] status_o,
  input logic [7:0] config_o,
  input logic       busy
);
  assert_grant_deny_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && deny));

  assert_deny_clears_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    deny |-> !status_o[1]);

  assert_grant_needs_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> $past(status_o[1]));

  assert_no_grant_when_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> !$past(busy));

  assert_busy_ends_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(array_done));

  assert_split_needs_full_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    config_o[0] |-> (status_o[3:2] == 2'b11));

  assert_busy_mirrors_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy == status_o[0]);
endmodule

bind sflash_wprot_ctrl sfwp_checker u_chk (
  .clk(clk), .rst_n(vol_rst_n), .array_done(array_done), .grant(grant), .deny(deny),
  .status_o(status_o), .config_o(config_o), .busy(busy)
);

// File: tb/sflash_wprot_ctrl_test.sv
`timescale 1ns/1ps
module sflash_wprot_ctrl_test;
  localparam int K_WREN = 0, K_WRDI = 1, K_WRSR = 2, K_WRCR = 3,
                 K_PP = 4, K_SE = 5, K_BE = 6, K_CE = 7;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic por_n, nv_rst_n;
  logic cmd_wren, cmd_wrdi, cmd_wrsr, cmd_wrcr, cmd_pp, cmd_se, cmd_be, cmd_ce;
  logic [16:0] addr;
  logic [7:0]  wdata;
  logic        wp_n, array_done;
  logic        grant, deny, busy;
  logic [16:0] grant_lo, grant_hi;
  logic [7:0]  status_o, config_o;

  sflash_wprot_ctrl uut (
    .clk(clk), .por_n(por_n), .nv_rst_n(nv_rst_n),
    .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr), .cmd_wrcr(cmd_wrcr),
    .cmd_pp(cmd_pp), .cmd_se(cmd_se), .cmd_be(cmd_be), .cmd_ce(cmd_ce),
    .addr(addr), .wdata(wdata), .wp_n(wp_n), .array_done(array_done),
    .grant(grant), .deny(deny), .grant_lo(grant_lo), .grant_hi(grant_hi),
    .status_o(status_o), .config_o(config_o), .busy(busy)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input int kind, input int a, input int d);
    @(negedge clk);
    cmd_wren = (kind == K_WREN); cmd_wrdi = (kind == K_WRDI);
    cmd_wrsr = (kind == K_WRSR); cmd_wrcr = (kind == K_WRCR);
    cmd_pp   = (kind == K_PP);   cmd_se   = (kind == K_SE);
    cmd_be   = (kind == K_BE);   cmd_ce   = (kind == K_CE);
    addr = 17'(a); wdata = 8'(d);
    @(negedge clk);
    {cmd_wren, cmd_wrdi, cmd_wrsr, cmd_wrcr, cmd_pp, cmd_se, cmd_be, cmd_ce} = '0;
  endtask

  task automatic finish_op();
    @(negedge clk); array_done = 1'b1;
    @(negedge clk); array_done = 1'b0;
  endtask

  task automatic set_status(input int rc, input int lk);
    issue(K_WREN, 0, 0);
    issue(K_WRSR, 0, (lk << 7) | (rc << 2));
    finish_op();
  endtask

  task automatic set_config(input int split, input int sub);
    issue(K_WREN, 0, 0);
    issue(K_WRCR, 0, (sub << 1) | split);
  endtask

  function automatic bit exp_region(input int rc, input int a);
    return (rc == 3) || (rc == 2 && a >= 'h10000) || (rc == 1 && a >= 'h18000);
  endfunction

  function automatic bit exp_locked(input int kind, input int rc, input int split, input int sub, input int a);
    if (kind != K_BE && split != 0 && a < 'h1000) return bit'((sub >> (a / 1024)) & 1);
    return exp_region(rc, a);
  endfunction

  task automatic sweep(input int rc, input int split, input int sub);
    for (int k = 0; k < 128; k++) begin
      int a;
      a = k * 1024 + ((k * 37) % 1024);
      for (int kind = K_PP; kind <= K_BE; kind++) begin
        bit lk;
        int lo, hi;
        lk = exp_locked(kind, rc, split, sub, a);
        if (kind == K_PP) begin lo = a; hi = a | 'hFF; end
        else if (kind == K_SE && split != 0 && a < 'h1000) begin lo = a & ~'h3FF; hi = lo + 'h3FF; end
        else if (kind == K_SE) begin lo = a & ~'hFFF; hi = lo + 'hFFF; end
        else begin lo = a & ~'h7FFF; hi = lo + 'h7FFF; end
        issue(K_WREN, 0, 0);
        issue(kind, a, 0);
        check(grant == !lk && deny == lk, "R8/R10 grant decision", {grant, deny}, {!lk, lk});
        if (!lk) begin
          check(grant_lo == 17'(lo) && grant_hi == 17'(hi), "R12 range",
                int'(grant_lo), lo);
          check(busy == 1'b1, "R5 busy set", busy, 1);
          finish_op();
          check(status_o[1:0] == 2'b00, "R5 done clears busy and latch", status_o[1:0], 0);
        end else begin
          check(status_o[1:0] == 2'b00, "R4 deny clears latch, no busy", status_o[1:0], 0);
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    {cmd_wren, cmd_wrdi, cmd_wrsr, cmd_wrcr, cmd_pp, cmd_se, cmd_be, cmd_ce} = '0;
    addr = '0; wdata = '0; wp_n = 1'b1; array_done = 1'b0;
    por_n = 1'b0; nv_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; nv_rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check(status_o == 8'h00 && config_o == 8'h00 && !busy, "R1 reset state", status_o, 0);

    // R2 latch set and clear
    issue(K_WREN, 0, 0);
    check(status_o == 8'h02, "R2 write enable sets latch", status_o, 8'h02);
    issue(K_WRDI, 0, 0);
    check(status_o == 8'h00, "R2 write disable clears latch", status_o, 0);

    // R3 no latch
    for (int kind = K_WRSR; kind <= K_CE; kind++) begin
      issue(kind, 'h100, 8'h0C);
      check(deny && !grant, "R3 denied without latch", {grant, deny}, 1);
    end
    check(status_o == 8'h00, "R3 state untouched", status_o, 0);

    // R6 busy rejection
    issue(K_WREN, 0, 0);
    issue(K_PP, 'h40, 0);
    check(grant && busy, "R5 program granted", {grant, busy}, 3);
    issue(K_WREN, 0, 0);
    issue(K_SE, 'h2000, 0);
    check(deny && busy, "R6 denied while busy", {deny, busy}, 3);
    finish_op();
    check(!busy, "R5 done ends busy", busy, 0);

    // R7 lock bit and pin
    set_status(1, 1);
    check(status_o == 8'h84, "R7 status loaded", status_o, 8'h84);
    wp_n = 1'b0;
    issue(K_WREN, 0, 0);
    issue(K_WRSR, 0, 8'h00);
    check(deny && status_o == 8'h84, "R7 locked with pin low", status_o, 8'h84);
    wp_n = 1'b1;
    set_status(0, 0);
    check(status_o == 8'h00, "R7 unlocked with pin high", status_o, 0);

    // R11 chip erase
    set_status(2, 0);
    issue(K_WREN, 0, 0);
    issue(K_CE, 0, 0);
    check(deny, "R11 chip erase denied with code 2", deny, 1);
    set_status(0, 0);
    issue(K_WREN, 0, 0);
    issue(K_CE, 0, 0);
    check(grant && grant_lo == 0 && grant_hi == 17'h1FFFF, "R11 R12 chip erase range", grant_hi, 'h1FFFF);
    finish_op();

    // R9 split refused under code 0; sub bits stored but R10 no effect
    set_config(1, 'hF);
    check(config_o == 8'h1E && status_o[1] == 1'b0, "R9 split refused, R5 latch cleared", config_o, 8'h1E);
    issue(K_WREN, 0, 0);
    issue(K_PP, 'h0400, 0);
    check(grant, "R10 subsector bits inert without split", grant, 1);
    finish_op();

    // R9 split accepted under code 3, cleared by code change
    set_status(3, 0);
    set_config(1, 'h5);
    check(config_o == 8'h0B && !busy, "R9 split accepted, R5 no busy", config_o, 8'h0B);
    set_status(2, 0);
    check(config_o[0] == 1'b0, "R9 split cleared by code write", config_o, 8'h0A);

    // Sweeps R8 R10 R12
    for (int rc = 0; rc < 4; rc++) begin
      set_status(rc, 0);
      set_config(0, 0);
      sweep(rc, 0, 0);
    end
    set_status(3, 0);
    for (int sub = 0; sub < 16; sub++) begin
      set_config(1, sub);
      check(config_o == 8'((sub << 1) | 1), "R9 config readback", config_o, (sub << 1) | 1);
      sweep(3, 1, sub);
    end

    // R1 power-on reset keeps non-volatile bits
    set_status(2, 1);
    issue(K_WREN, 0, 0);
    @(negedge clk); por_n = 1'b0;
    repeat (2) @(negedge clk); por_n = 1'b1;
    repeat (3) @(negedge clk);
    check(status_o == 8'h88 && config_o == 8'h00, "R1 power-on keeps code and lock", status_o, 8'h88);
    @(negedge clk); nv_rst_n = 1'b0;
    repeat (2) @(negedge clk); nv_rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(status_o == 8'h00, "R1 non-volatile reset clears all", status_o, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule